// File: doc/BRIEF.md
# Serial Character Receiver with Control and Status Register

This block receives asynchronous serial characters. A character arrives as one low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The receiver watches the line through a two-flop synchronizer. It counts a free-running oversampling tick at sixteen ticks per bit and takes each bit near its centre.

Software reaches the block through one control/status byte and one read-only data byte. The control/status byte holds three settings: receive enable, parity enable and parity polarity. It also holds the buffer-full flag and three sticky error flags (parity, overrun, framing). Reading the status byte hands the character over to software and clears the buffer-full flag. An error flag is cleared by writing a zero into its bit.

Top module: `uart_rx_core`

## Requirements
- R1: The status byte reads as follows. Bit 6 is the parity polarity select and bit 5 the parity enable. Bit 4 is the parity error, bit 3 the overrun error and bit 2 the framing error. Bit 1 is buffer-full and bit 0 the receive enable. Bit 7 always reads 0. After reset the byte is 0x00.
- R2: With parity enabled, a parity bit follows the eighth data bit. With polarity select 1 (even), the data bits plus the parity bit must hold an even number of ones. With polarity select 0 (odd), they must hold an odd number. A mismatch sets the parity error flag. With parity disabled, the bit after the data is the stop bit.
- R3: The error flags in bits 4, 3 and 2 are set only by hardware. A control write clears a flag only when it carries 0 in that flag's bit. Writing 1 leaves the flag as it was.
- R4: Buffer-full goes to 1 one clock after the stop bit of a character is sampled. Bit 1 of a control write has no effect.
- R5: A status read pulse clears buffer-full on the next clock, unless a character completes in that same cycle.
- R6: A control write that takes receive enable from 0 to 1 clears buffer-full.
- R7: The data output holds the last accepted character. It is 0x00 after reset and cannot be written.
- R8: An overrun occurs when a character completes while buffer-full is 1 and no status read is pulsed in that cycle. The overrun flag is then set, and the data output keeps the previous character.
- R9: A stop bit sampled as 0 sets the framing error flag. That character is still loaded and buffer-full is still set.
- R10: Bits are taken at 16 oversampling ticks per bit. The start bit is checked 8 ticks after the first low tick, and each later bit is taken 16 ticks after the one before it. Data bits arrive least significant bit first.
- R11: If the line is high again when the start bit is checked, the receiver returns to idle. No flag changes.
- R12: While receive enable is 0, the receiver stays idle and no character completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| os_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| ctl_wr | input | 1 | Write strobe for the control/status byte |
| ctl_wdata | input | 8 | Control write data |
| stat_rd | input | 1 | Status read strobe, clears buffer-full |
| status | output | 8 | Control/status byte |
| rx_data | output | DATA_W | Received character |
| buf_full | output | 1 | Buffer-full flag |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |
| frm_err | output | 1 | Sticky framing error |

## Verification
The line reaches the bit sampler two clocks after it changes, through the synchronizer. The stop bit is taken on the tick 8 + 16·9 ticks after the first low tick, or 8 + 16·10 ticks with parity. The data, buffer-full and error flags change on the clock after that sampling edge. Control writes and status reads show one clock after their strobe. A behavioural bench model applies these same delays and is compared with every output at each falling edge, away from the active edge. Scenario checks are placed two bit times after each frame, once every result has settled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int ST_PSEL = 6;
  localparam int ST_PEN  = 5;
  localparam int ST_PERR = 4;
  localparam int ST_OERR = 3;
  localparam int ST_FERR = 2;
  localparam int ST_FULL = 1;
  localparam int ST_EN   = 0;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic              par_en,
  input  logic              par_even,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_bad,
  output logic              stop_bad
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      done     <= 1'b0;
      par_bad  <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!line) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == MID_CNT) begin
              if (line) begin
                state <= RX_IDLE;
              end else begin
                state   <= RX_DATA;
                cnt     <= '0;
                idx     <= '0;
                par_bad <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == LAST_CNT) begin
              cnt   <= '0;
              shreg <= {line, shreg[DATA_W-1:1]};
              if (idx == LAST_IDX) state <= par_en ? RX_PAR : RX_STOP;
              else                 idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (cnt == LAST_CNT) begin
              cnt     <= '0;
              par_bad <= ((^shreg) ^ line) == par_even;
              state   <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == LAST_CNT) begin
              done     <= 1'b1;
              stop_bad <= !line;
              state    <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign data = shreg;
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              stat_rd,
  input  logic              done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              par_bad,
  input  logic              stop_bad,
  output logic              en,
  output logic              par_en,
  output logic              par_even,
  output logic              full,
  output logic              perr,
  output logic              oerr,
  output logic              ferr,
  output logic [DATA_W-1:0] rdata
);
  logic overrun, accept, en_rise;
  logic unused_wbits;

  assign overrun      = done & full & ~stat_rd;
  assign accept       = done & ~overrun;
  assign en_rise      = ctl_wr & ctl_wdata[ST_EN] & ~en;
  assign unused_wbits = ^{ctl_wdata[7], ctl_wdata[ST_FULL]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      par_en   <= 1'b0;
      par_even <= 1'b0;
      full     <= 1'b0;
      perr     <= 1'b0;
      oerr     <= 1'b0;
      ferr     <= 1'b0;
      rdata    <= '0;
    end else begin
      if (ctl_wr) begin
        en       <= ctl_wdata[ST_EN];
        par_en   <= ctl_wdata[ST_PEN];
        par_even <= ctl_wdata[ST_PSEL];
      end
      perr <= (perr & (~ctl_wr | ctl_wdata[ST_PERR])) | (done & par_bad);
      oerr <= (oerr & (~ctl_wr | ctl_wdata[ST_OERR])) | overrun;
      ferr <= (ferr & (~ctl_wr | ctl_wdata[ST_FERR])) | (done & stop_bad);
      if (done)                   full <= 1'b1;
      else if (stat_rd | en_rise) full <= 1'b0;
      if (accept) rdata <= frame_data;
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  input  logic              os_tick,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              stat_rd,
  output logic [7:0]        status,
  output logic [DATA_W-1:0] rx_data,
  output logic              buf_full,
  output logic              par_err,
  output logic              ovr_err,
  output logic              frm_err
);
  logic              line_s;
  logic              en, par_en, par_even;
  logic              frame_done, frame_par_bad, frame_stop_bad;
  logic [DATA_W-1:0] frame_data;

  uart_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(rx_in), .q(line_s)
  );

  uart_rx_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
    .clk(clk), .rst(rst), .en(en), .tick(os_tick), .line(line_s),
    .par_en(par_en), .par_even(par_even), .done(frame_done),
    .data(frame_data), .par_bad(frame_par_bad), .stop_bad(frame_stop_bad)
  );

  uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .stat_rd(stat_rd), .done(frame_done), .frame_data(frame_data),
    .par_bad(frame_par_bad), .stop_bad(frame_stop_bad),
    .en(en), .par_en(par_en), .par_even(par_even), .full(buf_full),
    .perr(par_err), .oerr(ovr_err), .ferr(frm_err), .rdata(rx_data)
  );

  always_comb begin
    status          = '0;
    status[ST_PSEL] = par_even;
    status[ST_PEN]  = par_en;
    status[ST_PERR] = par_err;
    status[ST_OERR] = ovr_err;
    status[ST_FERR] = frm_err;
    status[ST_FULL] = buf_full;
    status[ST_EN]   = en;
  end
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_wr,
  input logic              stat_rd,
  input logic              done,
  input logic              stop_bad,
  input logic [7:0]        status,
  input logic [DATA_W-1:0] rx_data,
  input logic              buf_full,
  input logic              par_err,
  input logic              ovr_err,
  input logic              frm_err
);
  always @(negedge clk) begin
    if (!rst) assert_bit7_zero_R1: assert (status[7] == 1'b0);
  end

  assert_full_on_char_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> buf_full);

  assert_full_clear_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !done |=> !buf_full);

  assert_perr_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    par_err && !ctl_wr |=> par_err);

  assert_oerr_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    ovr_err && !ctl_wr |=> ovr_err);

  assert_ferr_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    frm_err && !ctl_wr |=> frm_err);

  assert_overrun_keeps_data_R8: assert property (@(posedge clk) disable iff (rst)
    done && buf_full && !stat_rd |=> ovr_err && $stable(rx_data));

  assert_frame_err_loads_R9: assert property (@(posedge clk) disable iff (rst)
    done && stop_bad |=> frm_err && buf_full);

  assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (rst)
    !status[0] |=> !done);
endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .stat_rd(stat_rd),
  .done(frame_done), .stop_bad(frame_stop_bad), .status(status),
  .rx_data(rx_data), .buf_full(buf_full), .par_err(par_err),
  .ovr_err(ovr_err), .frm_err(frm_err)
);

// File: tb/uart_rx_core_tb.sv
`timescale 1ns/1ps
module uart_rx_core_tb;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_in = 1'b1;
  logic       os_tick = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       stat_rd = 1'b0;
  logic [7:0] status;
  logic [7:0] rx_data;
  logic       buf_full, par_err, ovr_err, frm_err;

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;
  bit finished = 0;
  int tdiv = 0;

  always #10 clk = ~clk;

  uart_rx_core u_dut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .os_tick(os_tick),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_rd(stat_rd),
    .status(status), .rx_data(rx_data), .buf_full(buf_full),
    .par_err(par_err), .ovr_err(ovr_err), .frm_err(frm_err)
  );

  always @(negedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICK_DIV - 1);
  end

  // behavioural reference model
  bit m_en, m_psel, m_pen, m_perr, m_oerr, m_ferr, m_full;
  bit [7:0] m_data, m_byte;
  bit s1, s2, m_pen_l, m_pbad;
  int ph;
  bit pend_done, pend_pbad, pend_sbad;
  bit [7:0] pend_byte;

  always @(posedge clk) begin
    bit line, old_en, old_pen, old_psel, old_full, ovr, en_rise, nd, nsb;
    int k;
    if (rst) begin
      {m_en, m_psel, m_pen, m_perr, m_oerr, m_ferr, m_full} = '0;
      m_data = 0; m_byte = 0; s1 = 1; s2 = 1; ph = -1;
      pend_done = 0; pend_pbad = 0; pend_sbad = 0; pend_byte = 0;
      m_pen_l = 0; m_pbad = 0;
    end else begin
      line = s2; old_en = m_en; old_pen = m_pen; old_psel = m_psel;
      old_full = m_full;
      ovr = pend_done && old_full && !stat_rd;
      en_rise = ctl_wr && ctl_wdata[0] && !old_en;
      if (ctl_wr) begin
        m_en = ctl_wdata[0]; m_pen = ctl_wdata[5]; m_psel = ctl_wdata[6];
        if (!ctl_wdata[4]) m_perr = 0;
        if (!ctl_wdata[3]) m_oerr = 0;
        if (!ctl_wdata[2]) m_ferr = 0;
      end
      if (pend_done) begin
        if (pend_pbad) m_perr = 1;
        if (pend_sbad) m_ferr = 1;
        if (ovr) m_oerr = 1; else m_data = pend_byte;
        m_full = 1;
      end else if (stat_rd || en_rise) m_full = 0;
      nd = 0; nsb = 0;
      if (!old_en) ph = -1;
      else if (os_tick) begin
        if (ph < 0) begin
          if (!line) begin ph = 0; m_pbad = 0; end
        end else begin
          ph++;
          if (ph == 8) begin
            if (line) ph = -1;
          end else if (ph > 8 && (ph - 8) % 16 == 0) begin
            k = (ph - 8) / 16 - 1;
            if (k < 8) m_byte[k] = line;
            if (k == 7) m_pen_l = old_pen;
            if (k == 8 && m_pen_l) m_pbad = ((^m_byte) ^ line) == old_psel;
            if (k == 8 + int'(m_pen_l)) begin nd = 1; nsb = !line; ph = -1; end
          end
        end
      end
      pend_done = nd; pend_byte = m_byte; pend_pbad = m_pbad && m_pen_l;
      pend_sbad = nsb;
      s2 = s1; s1 = rx_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 status model", status,
          {1'b0, m_psel, m_pen, m_perr, m_oerr, m_ferr, m_full, m_en});
      chk("R7 data model", rx_data, m_data);
      chk("R4 full model", buf_full, m_full);
      chk("R2 perr model", par_err, m_perr);
      chk("R8 oerr model", ovr_err, m_oerr);
      chk("R9 ferr model", frm_err, m_ferr);
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic hold(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit wp, input bit pb, input bit sb);
    hold(0, BIT_CLK);
    for (int i = 0; i < 8; i++) hold(b[i], BIT_CLK);
    if (wp) hold(pb, BIT_CLK);
    hold(sb, BIT_CLK);
    hold(1, 2 * BIT_CLK);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cmp_on = 1;
    chk("R1 reset status", status, 8'h00);
    chk("R7 reset data", rx_data, 8'h00);
    chk("R4 reset full", buf_full, 0);

    wr_ctl(8'h01);
    chk("R1 enable bit0", status, 8'h01);
    send(8'hA5, 0, 0, 1);
    chk("R10 lsb first data", rx_data, 8'hA5);
    chk("R4 full set", buf_full, 1);
    chk("R1 status full", status, 8'h03);

    send(8'h3C, 0, 0, 1);
    chk("R8 overrun flag", ovr_err, 1);
    chk("R8 data kept", rx_data, 8'hA5);
    chk("R1 status overrun", status, 8'h0B);
    rd_stat();
    chk("R5 read clears full", buf_full, 0);

    wr_ctl(8'h1F);
    chk("R3 write one keeps flag", ovr_err, 1);
    chk("R4 full not writable", buf_full, 0);
    wr_ctl(8'h01);
    chk("R3 write zero clears", ovr_err, 0);

    wr_ctl(8'h61);
    send(8'h0F, 1, 0, 1);
    chk("R2 even ok", par_err, 0);
    chk("R2 even data", rx_data, 8'h0F);
    rd_stat();
    send(8'h0F, 1, 1, 1);
    chk("R2 even bad", par_err, 1);
    rd_stat();
    wr_ctl(8'h21);
    chk("R3 perr cleared", par_err, 0);
    send(8'h01, 1, 0, 1);
    chk("R2 odd ok", par_err, 0);
    rd_stat();
    send(8'h03, 1, 0, 1);
    chk("R2 odd bad", par_err, 1);
    rd_stat();
    wr_ctl(8'h01);
    send(8'h55, 0, 0, 1);
    chk("R2 no parity bit", par_err, 0);
    chk("R2 no parity data", rx_data, 8'h55);
    chk("R9 good stop", frm_err, 0);
    rd_stat();

    send(8'h81, 0, 0, 0);
    chk("R9 framing flag", frm_err, 1);
    chk("R9 data loaded", rx_data, 8'h81);
    chk("R9 full set", buf_full, 1);
    rd_stat();
    wr_ctl(8'h01);

    hold(0, 3 * TICK_DIV);
    hold(1, 3 * BIT_CLK);
    chk("R11 glitch no full", buf_full, 0);
    chk("R11 glitch status", status, 8'h01);
    chk("R11 glitch data", rx_data, 8'h81);

    send(8'h42, 0, 0, 1);
    wr_ctl(8'h00);
    send(8'h99, 0, 0, 1);
    chk("R12 disabled data", rx_data, 8'h42);
    chk("R12 disabled status", status, 8'h02);
    wr_ctl(8'h01);
    chk("R6 enable clears full", buf_full, 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule